// File: doc/BRIEF.md
# Acknowledged serial link byte engine

This block is one end of a point-to-point serial link. It has one output wire and one input wire, and it holds a transmit path and a receive path. The transmit path moves a block of bytes. A start command gives the block its length and the address of its first byte. For each byte the path reads one byte from a source memory port, sends it on the output wire as a framed data word, and waits for the partner to acknowledge it before it moves to the next byte. When the last byte has been acknowledged, a done flag rises.

The receive path is armed with a destination address and a byte count. It decodes frames from the input wire and writes each good data byte to a destination memory port at the next address. After each stored byte it sends a short acknowledge frame back on its own output wire. That ack can fall between outgoing data frames of its own block.

Two instances wired back to back give a full-duplex link that moves blocks both ways at the same time. All line timing is one bit per clock cycle, and the idle line is low.

Top module: `link_endpoint`

## Requirements
- R1: While reset is held and just after it is released, `line_out` is 0, `tx_done` and `rx_done` are 0, and `src_rd_en` and `dst_we` are 0.
- R2: A data frame is 11 bits with one bit per clock cycle, in this order: 1, 1, the eight data bits least significant first, then 0. The line is 0 when no frame is being sent.
- R3: After each byte it stores, the receive path sends the two-bit acknowledge frame 1 then 0 on `line_out`. An ack that becomes due while a frame is on the line waits for that frame to end, and it goes ahead of the next data frame.
- R4: A `tx_start` with a nonzero `tx_count` N reads bytes from `tx_base`, `tx_base+1`, … through `src_rd_en`/`src_addr`, and takes `src_rd_data` one cycle after each read. Each byte is sent only after the previous one has been acknowledged. `tx_done` falls on the start and rises once the N-th ack has arrived, then holds until the next start.
- R5: A `tx_start` with `tx_count` 0 sets `tx_done` one cycle later and reads nothing.
- R6: A `tx_start` that arrives while a block is in progress is ignored. The running block keeps its count, its addresses and its timing.
- R7: An acknowledge frame that arrives while the transmit path is not waiting for one has no effect on the count or on the timing of the block.
- R8: `rx_start` loads `rx_base` and `rx_count`. Each good data byte is written once, through `dst_we`/`dst_addr`/`dst_wdata`, at the next destination address. `rx_done` rises together with the write that uses up the count, or one cycle after an `rx_start` whose count is 0.
- R9: A data byte that arrives when the receive count is zero is neither stored nor acknowledged.
- R10: A data frame whose last bit is 1 instead of 0 is thrown away. It is neither stored nor acknowledged.
- R11: Two instances cross-wired can run blocks in both directions at once. Acks share each wire with data frames, and both blocks arrive intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_out | output | 1 | Serial output wire (data and ack frames) |
| line_in | input | 1 | Serial input wire from the partner |
| tx_start | input | 1 | One-cycle pulse that starts a transmit block |
| tx_count | input | CNT_W | Number of bytes in the transmit block |
| tx_base | input | ADDR_W | Source address of the first byte |
| tx_done | output | 1 | Transmit block finished (level) |
| src_rd_en | output | 1 | Source read strobe |
| src_addr | output | ADDR_W | Source read address |
| src_rd_data | input | 8 | Source byte, valid the cycle after the strobe |
| rx_start | input | 1 | One-cycle pulse that arms the receive path |
| rx_count | input | CNT_W | Number of bytes to accept |
| rx_base | input | ADDR_W | Destination address of the first byte |
| rx_done | output | 1 | Receive count used up (level) |
| dst_we | output | 1 | Destination write strobe |
| dst_addr | output | ADDR_W | Destination write address |
| dst_wdata | output | 8 | Destination write byte |

## Verification
Take the edge that samples `tx_start` as cycle 0 and a link whose reverse wire is otherwise quiet. Then the read strobe is up right after that edge. Data bits appear on the wire after edges 3 through 13. The partner's write strobe is up after edge 15, and its ack bits come after edges 16 and 17. `tx_done` rises after edge 19 × N. The bench drives inputs and samples outputs on falling edges. It counts exactly that many rising edges to each point, so every timed check looks at the one cycle where the result is due, and it also checks the cycle just before the done flag rises. Checks on transfers in both directions, on injected frames and on overflow bytes do not depend on exact timing. They look at the memory contents, the done flags and the wire after a fixed settling window.

// File: rtl/link_pkg.sv
package link_pkg;
    localparam int BYTE_W   = 8;
    // start, start, byte, stop
    localparam int FRAME_W  = BYTE_W + 3;
    localparam int ACK_W    = 2;
    localparam int REM_W    = $clog2(FRAME_W);

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_FETCH,
        TX_LOAD,
        TX_SEND,
        TX_WAIT
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_KIND,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/link_line_tx.sv
// Output wire serializer: sends data frames and ack frames, one bit per cycle.
module link_line_tx
    import link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_req,
    input  logic [BYTE_W-1:0] data_byte,
    output logic              data_take,
    input  logic              ack_req,
    output logic              line_out
);
    typedef struct packed {
        logic               busy;
        logic [REM_W-1:0]   rem;
        logic [FRAME_W-1:0] sh;
        logic               line;
        logic               ack_pend;
    } ser_t;

    localparam logic [REM_W-1:0]   DATA_LAST = REM_W'(FRAME_W - 1);
    localparam logic [REM_W-1:0]   ACK_LAST  = REM_W'(ACK_W - 1);
    localparam logic [REM_W-1:0]   REM_ONE   = REM_W'(1);
    // ack bits LSB first: 1 then 0
    localparam logic [FRAME_W-1:0] ACK_FRAME = FRAME_W'(2'b01);

    ser_t q, d;
    logic free;
    logic want_ack;
    logic [FRAME_W-1:0] frame;

    always_comb begin
        d         = q;
        data_take = 1'b0;
        frame     = {1'b0, data_byte, 2'b11};
        free      = !q.busy || (q.rem == '0);
        want_ack  = q.ack_pend || ack_req;
        d.ack_pend = q.ack_pend || ack_req;
        if (!free) begin
            d.line = q.sh[0];
            d.sh   = q.sh >> 1;
            d.rem  = q.rem - REM_ONE;
        end else if (want_ack) begin
            d.line     = ACK_FRAME[0];
            d.sh       = ACK_FRAME >> 1;
            d.rem      = ACK_LAST;
            d.busy     = 1'b1;
            d.ack_pend = 1'b0;
        end else if (data_req) begin
            d.line    = frame[0];
            d.sh      = frame >> 1;
            d.rem     = DATA_LAST;
            d.busy    = 1'b1;
            data_take = 1'b1;
        end else begin
            d.line = 1'b0;
            d.busy = 1'b0;
            d.rem  = '0;
            d.sh   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line_out = q.line;
endmodule

// File: rtl/link_line_rx.sv
// Input wire decoder: tells data frames from ack frames and checks the stop bit.
module link_line_rx
    import link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_val,
    output logic              ack_seen
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              vld;
        logic [BYTE_W-1:0] val;
        logic              ack;
    } des_t;

    des_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.ack = 1'b0;
        unique case (q.st)
            RX_IDLE: if (line_in) d.st = RX_KIND;
            RX_KIND: begin
                if (line_in) begin
                    d.st  = RX_DATA;
                    d.cnt = '0;
                end else begin
                    d.ack = 1'b1;
                    d.st  = RX_IDLE;
                end
            end
            RX_DATA: begin
                d.sh  = {line_in, q.sh[BYTE_W-1:1]};
                d.cnt = q.cnt + CNT_ONE;
                if (q.cnt == CNT_LAST) d.st = RX_STOP;
            end
            RX_STOP: begin
                if (!line_in) begin
                    d.vld = 1'b1;
                    d.val = q.sh;
                end
                d.st = RX_IDLE;
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_vld = q.vld;
    assign byte_val = q.val;
    assign ack_seen = q.ack;
endmodule

// File: rtl/link_tx_ctrl.sv
// Transmit block sequencer: fetch, send, wait for ack, count down.
module link_tx_ctrl
    import link_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [ADDR_W-1:0] tx_base,
    output logic              tx_done,
    output logic              src_rd_en,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [BYTE_W-1:0] src_rd_data,
    output logic              data_req,
    output logic [BYTE_W-1:0] data_byte,
    input  logic              data_take,
    input  logic              ack_seen
);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] ptr;
        logic [BYTE_W-1:0] hold;
        logic              done;
    } txc_t;

    txc_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            TX_IDLE: begin
                if (tx_start) begin
                    if (tx_count == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.done = 1'b0;
                        d.cnt  = tx_count;
                        d.ptr  = tx_base;
                        d.st   = TX_FETCH;
                    end
                end
            end
            TX_FETCH: d.st = TX_LOAD;
            TX_LOAD: begin
                d.hold = src_rd_data;
                d.st   = TX_SEND;
            end
            TX_SEND: if (data_take) d.st = TX_WAIT;
            TX_WAIT: begin
                if (ack_seen) begin
                    d.cnt = q.cnt - CNT_ONE;
                    d.ptr = q.ptr + ADDR_ONE;
                    if (q.cnt == CNT_ONE) begin
                        d.done = 1'b1;
                        d.st   = TX_IDLE;
                    end else begin
                        d.st = TX_FETCH;
                    end
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_done   = q.done;
    assign src_rd_en = (q.st == TX_FETCH);
    assign src_addr  = q.ptr;
    assign data_req  = (q.st == TX_SEND);
    assign data_byte = q.hold;
endmodule

// File: rtl/link_rx_ctrl.sv
// Receive block store: writes good bytes in order and asks for an ack for each.
module link_rx_ctrl
    import link_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [ADDR_W-1:0] rx_base,
    output logic              rx_done,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_val,
    output logic              dst_we,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [BYTE_W-1:0] dst_wdata,
    output logic              ack_req
);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] ptr;
        logic              done;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
        logic              ack;
    } rxc_t;

    rxc_t q, d;

    always_comb begin
        d     = q;
        d.we  = 1'b0;
        d.ack = 1'b0;
        if (rx_start) begin
            d.cnt  = rx_count;
            d.ptr  = rx_base;
            d.done = (rx_count == '0);
        end else if (byte_vld && (q.cnt != '0)) begin
            d.we    = 1'b1;
            d.addr  = q.ptr;
            d.wdata = byte_val;
            d.ptr   = q.ptr + ADDR_ONE;
            d.cnt   = q.cnt - CNT_ONE;
            d.ack   = 1'b1;
            d.done  = (q.cnt == CNT_ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_done   = q.done;
    assign dst_we    = q.we;
    assign dst_addr  = q.addr;
    assign dst_wdata = q.wdata;
    assign ack_req   = q.ack;
endmodule

// File: rtl/link_endpoint.sv
module link_endpoint
    import link_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              line_out,
    input  logic              line_in,
    input  logic              tx_start,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [ADDR_W-1:0] tx_base,
    output logic              tx_done,
    output logic              src_rd_en,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [7:0]        src_rd_data,
    input  logic              rx_start,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [ADDR_W-1:0] rx_base,
    output logic              rx_done,
    output logic              dst_we,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [7:0]        dst_wdata
);
    logic              data_req;
    logic [BYTE_W-1:0] data_byte;
    logic              data_take;
    logic              ack_req;
    logic              in_vld;
    logic [BYTE_W-1:0] in_byte;
    logic              in_ack;

    link_tx_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_txc (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_start    (tx_start),
        .tx_count    (tx_count),
        .tx_base     (tx_base),
        .tx_done     (tx_done),
        .src_rd_en   (src_rd_en),
        .src_addr    (src_addr),
        .src_rd_data (src_rd_data),
        .data_req    (data_req),
        .data_byte   (data_byte),
        .data_take   (data_take),
        .ack_seen    (in_ack)
    );

    link_line_tx u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_req  (data_req),
        .data_byte (data_byte),
        .data_take (data_take),
        .ack_req   (ack_req),
        .line_out  (line_out)
    );

    link_line_rx u_des (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .byte_vld (in_vld),
        .byte_val (in_byte),
        .ack_seen (in_ack)
    );

    link_rx_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rxc (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_start  (rx_start),
        .rx_count  (rx_count),
        .rx_base   (rx_base),
        .rx_done   (rx_done),
        .byte_vld  (in_vld),
        .byte_val  (in_byte),
        .dst_we    (dst_we),
        .dst_addr  (dst_addr),
        .dst_wdata (dst_wdata),
        .ack_req   (ack_req)
    );
endmodule

// File: rtl/link_endpoint_chk.sv
module link_endpoint_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_start,
    input logic tx_done,
    input logic src_rd_en,
    input logic rx_start,
    input logic rx_done,
    input logic dst_we
);
    // R4: each fetch is a single-cycle strobe
    p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_en |=> !src_rd_en);

    // R4: done holds until a new start
    p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !tx_start) |=> tx_done);

    // R5: no read while the transmit side reports done
    p_done_no_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !src_rd_en);

    // R8: writes are single-cycle strobes
    p_we_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |=> !dst_we);

    // R9: nothing is stored once the receive count is used up
    p_no_store_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_start) |=> !dst_we);
endmodule

bind link_endpoint link_endpoint_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_start  (tx_start),
    .tx_done   (tx_done),
    .src_rd_en (src_rd_en),
    .rx_start  (rx_start),
    .rx_done   (rx_done),
    .dst_we    (dst_we)
);

// File: tb/test_link_endpoint.sv
module test_link_endpoint;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 9;
    localparam int CW  = 10;
    localparam int MEM = 512;
    localparam int PER_BYTE = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          a_out, a_in, b_out, b_in;
    logic          a_tx_start, b_tx_start, a_rx_start, b_rx_start;
    logic [CW-1:0] a_tx_count, b_tx_count, a_rx_count, b_rx_count;
    logic [AW-1:0] a_tx_base, b_tx_base, a_rx_base, b_rx_base;
    logic          a_tx_done, b_tx_done, a_rx_done, b_rx_done;
    logic          a_rd, b_rd, a_we, b_we;
    logic [AW-1:0] a_raddr, b_raddr, a_waddr, b_waddr;
    logic [7:0]    a_rdata, b_rdata, a_wdata, b_wdata;
    logic          inj_a, inj_a_val, inj_b, inj_b_val;

    assign a_in = inj_a ? inj_a_val : b_out;
    assign b_in = inj_b ? inj_b_val : a_out;

    logic [7:0] a_src [MEM];
    logic [7:0] b_src [MEM];
    logic [7:0] a_dst [MEM];
    logic [7:0] b_dst [MEM];
    logic       fill_req;

    always @(posedge clk) begin
        if (a_rd) a_rdata <= a_src[a_raddr];
        if (b_rd) b_rdata <= b_src[b_raddr];
        if (fill_req) begin
            for (int i = 0; i < MEM; i++) begin
                a_dst[i] <= 8'hEE;
                b_dst[i] <= 8'hEE;
            end
        end else begin
            if (a_we) a_dst[a_waddr] <= a_wdata;
            if (b_we) b_dst[b_waddr] <= b_wdata;
        end
    end

    link_endpoint #(.ADDR_W(AW), .CNT_W(CW)) i_link_endpoint (
        .clk(clk), .rst_n(rst_n), .line_out(a_out), .line_in(a_in),
        .tx_start(a_tx_start), .tx_count(a_tx_count), .tx_base(a_tx_base),
        .tx_done(a_tx_done), .src_rd_en(a_rd), .src_addr(a_raddr),
        .src_rd_data(a_rdata), .rx_start(a_rx_start), .rx_count(a_rx_count),
        .rx_base(a_rx_base), .rx_done(a_rx_done), .dst_we(a_we),
        .dst_addr(a_waddr), .dst_wdata(a_wdata)
    );

    link_endpoint #(.ADDR_W(AW), .CNT_W(CW)) i_link_endpoint_peer (
        .clk(clk), .rst_n(rst_n), .line_out(b_out), .line_in(b_in),
        .tx_start(b_tx_start), .tx_count(b_tx_count), .tx_base(b_tx_base),
        .tx_done(b_tx_done), .src_rd_en(b_rd), .src_addr(b_raddr),
        .src_rd_data(b_rdata), .rx_start(b_rx_start), .rx_count(b_rx_count),
        .rx_base(b_rx_base), .rx_done(b_rx_done), .dst_we(b_we),
        .dst_addr(b_waddr), .dst_wdata(b_wdata)
    );

    int n_chk  = 0;
    int n_fail = 0;
    logic seen;

    function automatic logic [7:0] fa(input int x);
        return 8'((x * 29 + 7) & 255);
    endfunction

    function automatic logic [7:0] fb(input int x);
        return 8'((x * 53 + 3) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic step_watch(input int n);
        repeat (n) begin
            @(negedge clk);
            seen = seen | b_out;
        end
    endtask

    task automatic fill_dst();
        fill_req = 1'b1;
        step(1);
        fill_req = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        a_tx_start = 0; b_tx_start = 0; a_rx_start = 0; b_rx_start = 0;
        inj_a = 0; inj_b = 0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic arm_b(input int cnt, input int base);
        b_rx_count = CW'(cnt);
        b_rx_base  = AW'(base);
        b_rx_start = 1'b1;
    endtask

    task automatic go_a(input int cnt, input int base);
        a_tx_count = CW'(cnt);
        a_tx_base  = AW'(base);
        a_tx_start = 1'b1;
    endtask

    task automatic release_starts();
        a_tx_start = 0; b_tx_start = 0; a_rx_start = 0; b_rx_start = 0;
    endtask

    task automatic send_frame_b(input logic [7:0] v, input logic stop);
        logic [10:0] f;
        f = {stop, v, 2'b11};
        for (int k = 0; k < 11; k++) begin
            inj_b = 1'b1;
            inj_b_val = f[k];
            step_watch(1);
        end
        inj_b = 1'b0;
        inj_b_val = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        fill_req = 0; inj_a = 0; inj_a_val = 0; inj_b = 0; inj_b_val = 0; seen = 0;
        a_tx_start = 0; b_tx_start = 0; a_rx_start = 0; b_rx_start = 0;
        a_tx_count = '0; b_tx_count = '0; a_rx_count = '0; b_rx_count = '0;
        a_tx_base = '0; b_tx_base = '0; a_rx_base = '0; b_rx_base = '0;
        for (int i = 0; i < MEM; i++) begin
            a_src[i] = fa(i);
            b_src[i] = fb(i);
        end
        step(2);
        // R1 during reset
        chk(a_out == 0 && a_tx_done == 0 && a_rx_done == 0, "R1", int'(a_out), 0);
        rst_n = 1'b1;
        step(1);
        chk(a_out == 0 && b_out == 0, "R1", int'(a_out | b_out), 0);
        chk(a_tx_done == 0 && a_rx_done == 0, "R1", int'(a_tx_done), 0);
        chk(a_rd == 0 && a_we == 0, "R1", int'(a_rd | a_we), 0);
        fill_dst();

        // R5 and R8: zero counts
        go_a(0, 3);
        arm_b(0, 7);
        step(1);
        release_starts();
        chk(a_tx_done == 1, "R5", int'(a_tx_done), 1);
        chk(a_rd == 0, "R5", int'(a_rd), 0);
        chk(b_rx_done == 1, "R8", int'(b_rx_done), 1);
        step(3);
        chk(a_rd == 0 && a_out == 0, "R5", int'(a_rd | a_out), 0);

        // single byte, cycle by cycle
        begin
            logic [10:0] fr;
            fr = {1'b0, fa(5), 2'b11};
            go_a(1, 5);
            arm_b(1, 32);
            step(1);
            release_starts();
            chk(a_rd == 1 && a_raddr == 5, "R4", int'(a_raddr), 5);
            chk(a_tx_done == 0, "R4", int'(a_tx_done), 0);
            for (int k = 1; k <= 19; k++) begin
                step(1);
                if (k >= 3 && k <= 13)
                    chk(a_out == fr[k-3], "R2", int'(a_out), int'(fr[k-3]));
                if (k == 15) begin
                    chk(b_we == 1, "R8", int'(b_we), 1);
                    chk(b_waddr == 32 && b_wdata == fa(5), "R8", int'(b_wdata), int'(fa(5)));
                end
                if (k == 16) chk(b_out == 1, "R3", int'(b_out), 1);
                if (k == 17) chk(b_out == 0, "R3", int'(b_out), 0);
                if (k == 18) chk(a_tx_done == 0, "R4", int'(a_tx_done), 0);
                if (k == 19) chk(a_tx_done == 1, "R4", int'(a_tx_done), 1);
            end
        end

        // R4 / R8: sweep of block lengths
        for (int n = 1; n <= 8; n++) begin
            int ba;
            int bb;
            ba = 3 * n;
            bb = 16 * n + 200;
            go_a(n, ba);
            arm_b(n, bb);
            step(1);
            release_starts();
            step(PER_BYTE * n - 1);
            chk(a_tx_done == 0, "R4", int'(a_tx_done), 0);
            step(1);
            chk(a_tx_done == 1, "R4", int'(a_tx_done), 1);
            chk(b_rx_done == 1, "R8", int'(b_rx_done), 1);
            step(1);
            for (int i = 0; i < n; i++)
                chk(b_dst[bb+i] == fa(ba+i), "R8", int'(b_dst[bb+i]), int'(fa(ba+i)));
            chk(b_dst[bb+n] == 8'hEE, "R8", int'(b_dst[bb+n]), 'hEE);
        end

        // R2 / R4: every byte value in one block
        go_a(256, 0);
        arm_b(256, 256);
        step(1);
        release_starts();
        step(PER_BYTE * 256 - 1);
        chk(a_tx_done == 0, "R4", int'(a_tx_done), 0);
        step(1);
        chk(a_tx_done == 1, "R4", int'(a_tx_done), 1);
        step(1);
        for (int i = 0; i < 256; i++)
            chk(b_dst[256+i] == fa(i), "R2", int'(b_dst[256+i]), int'(fa(i)));

        // R11: both directions at once
        fill_dst();
        a_rx_count = CW'(5); a_rx_base = AW'(100); a_rx_start = 1;
        b_tx_count = CW'(5); b_tx_base = AW'(50);  b_tx_start = 1;
        go_a(7, 20);
        arm_b(7, 400);
        step(1);
        release_starts();
        for (int c = 0; c < 600 && !(a_tx_done && b_tx_done); c++) step(1);
        step(2);
        chk(a_tx_done == 1 && b_tx_done == 1, "R11", int'(a_tx_done & b_tx_done), 1);
        chk(a_rx_done == 1 && b_rx_done == 1, "R11", int'(a_rx_done & b_rx_done), 1);
        for (int i = 0; i < 7; i++)
            chk(b_dst[400+i] == fa(20+i), "R11", int'(b_dst[400+i]), int'(fa(20+i)));
        for (int i = 0; i < 5; i++)
            chk(a_dst[100+i] == fb(50+i), "R11", int'(a_dst[100+i]), int'(fb(50+i)));

        // R6: start while busy
        fill_dst();
        go_a(3, 60);
        arm_b(3, 0);
        step(1);
        release_starts();
        step(5);
        go_a(1, 0);
        step(1);
        release_starts();
        step(50);
        chk(a_tx_done == 0, "R6", int'(a_tx_done), 0);
        step(1);
        chk(a_tx_done == 1, "R6", int'(a_tx_done), 1);
        step(1);
        for (int i = 0; i < 3; i++)
            chk(b_dst[i] == fa(60+i), "R6", int'(b_dst[i]), int'(fa(60+i)));
        chk(b_dst[3] == 8'hEE, "R6", int'(b_dst[3]), 'hEE);

        // R7: stray ack while fetching the second byte
        go_a(2, 70);
        arm_b(2, 10);
        step(1);
        release_starts();
        step(18);
        inj_a = 1; inj_a_val = 1;
        step(1);
        inj_a_val = 0;
        step(1);
        inj_a = 0;
        step(17);
        chk(a_tx_done == 0, "R7", int'(a_tx_done), 0);
        step(1);
        chk(a_tx_done == 1, "R7", int'(a_tx_done), 1);
        step(1);
        chk(b_dst[10] == fa(70) && b_dst[11] == fa(71), "R7", int'(b_dst[11]), int'(fa(71)));

        // R9: byte beyond receive count
        do_reset();
        fill_dst();
        go_a(2, 80);
        arm_b(1, 30);
        step(1);
        release_starts();
        step(80);
        chk(a_tx_done == 0, "R9", int'(a_tx_done), 0);
        chk(b_dst[30] == fa(80), "R9", int'(b_dst[30]), int'(fa(80)));
        chk(b_dst[31] == 8'hEE, "R9", int'(b_dst[31]), 'hEE);

        // R10: bad stop bit, then a good frame
        do_reset();
        fill_dst();
        arm_b(2, 64);
        step(1);
        release_starts();
        seen = 0;
        send_frame_b(8'h5A, 1'b1);
        step_watch(20);
        chk(b_dst[64] == 8'hEE, "R10", int'(b_dst[64]), 'hEE);
        chk(seen == 0, "R10", int'(seen), 0);
        seen = 0;
        send_frame_b(8'h3C, 1'b0);
        step_watch(20);
        chk(b_dst[64] == 8'h3C, "R8", int'(b_dst[64]), 'h3C);
        chk(seen == 1, "R3", int'(seen), 1);
        chk(b_rx_done == 0, "R8", int'(b_rx_done), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule